// File: doc/BRIEF.md
# Unaligned Partial-Store Byte-Lane Unit

This block turns one left or right partial store, in word (4-byte) or doubleword (8-byte) form, into a single masked write on a doubleword-wide bus. For each bus byte it works out whether that byte is written and which register byte goes into it. The inputs are the store data, the byte address, the operation and an endianness select. The output is registered once, as an aligned address, a data word and a per-byte strobe.

A lane index is taken from the low address bits. A left store starts at the addressed byte with the register's most significant byte of the operand and continues toward the end of the aligned group. A right store starts at the addressed byte with the least significant byte and continues the other way. Whether "toward the end" means rising or falling addresses depends on the endianness select. Every byte that one store touches lies inside the naturally aligned word or doubleword that holds the address, so one bus beat always carries the whole store.

The output stage is a two-state machine:
- `ST_IDLE`: no write is presented.
- `ST_EMIT`: a registered write is on the bus.

It has three transitions:
- ACCEPT (`ST_IDLE` to `ST_EMIT`) on a request.
- STREAM (`ST_EMIT` to `ST_EMIT`) on a back-to-back request.
- DRAIN (`ST_EMIT` to `ST_IDLE`) when no request arrives.

Top module: `partial_store_lanes`

## Requirements
- R1: During and directly after reset, `wr_valid` is 0 and `wr_strobe` is all zeros.
- R2: A request sampled at a clock edge appears on `wr_valid`/`wr_addr`/`wr_data`/`wr_strobe` after that same edge, so the latency is one cycle.
- R3: `req_op` encodes bit 1 = doubleword (1) or word (0), and bit 0 = right (1) or left (0). The lane index is `req_addr[1:0]` for word forms and `req_addr[2:0]` for doubleword forms when `req_big_endian`=1. When `req_big_endian`=0, the same bits are inverted.
- R4: A left store writes the operand's most significant byte at the addressed bus lane. With index i and group size n (4 or 8), it writes n-i bytes in total, taking operand bytes in falling significance.
- R5: A right store writes the operand's least significant byte at the addressed bus lane. It writes i+1 bytes in total, taking operand bytes in rising significance.
- R6: Successive bytes of a left store go to rising lanes in big-endian mode and to falling lanes in little-endian mode. A right store uses the opposite direction.
- R7: The doubleword forms apply R4 to R6 over all eight lanes with the full operand. The word forms use only `req_data[31:0]`.
- R8: `wr_addr` is `req_addr` with its low three bits cleared. Bus byte lane j (bits 8j+7:8j) is the byte at `wr_addr`+j. A word store enables only lanes inside the aligned word that holds the address.
- R9: A big-endian left word store at `req_addr[1:0]`=0, and a little-endian left word store at `req_addr[1:0]`=3, each enable all four lanes of their word.
- R10: In a cycle after an edge with no request, `wr_valid` is 0 and `wr_strobe` is all zeros.
- R11: `wr_data` bytes whose strobe bit is 0 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A partial store is presented this cycle |
| req_op | input | 2 | Bit 1 doubleword form, bit 0 right store |
| req_big_endian | input | 1 | 1 selects big-endian lane ordering |
| req_addr | input | ADDR_W | Byte address of the store |
| req_data | input | DATA_W | Register operand |
| wr_valid | output | 1 | Registered bus write is valid |
| wr_addr | output | ADDR_W | Doubleword-aligned bus address |
| wr_data | output | DATA_W | Bus data, one byte per lane |
| wr_strobe | output | DATA_W/8 | Per-lane write enable |

## Verification
The combinational assertions assume that the request inputs are stable and known around each rising edge. Byte counts are checked against the decoded index only when `req_valid` is high. The stimulus therefore changes every request input on the falling edge and holds `req_valid` low whenever the operand fields are not meaningful. Every pairing of operation, endianness and lane offset is driven, so each assertion sees every index value in both directions.

// File: rtl/pst_pkg.sv
package pst_pkg;

    // Operation code: bit 1 selects the doubleword form, bit 0 the right store.
    typedef enum logic [1:0] {
        OP_LEFT_W  = 2'b00,
        OP_RIGHT_W = 2'b01,
        OP_LEFT_D  = 2'b10,
        OP_RIGHT_D = 2'b11
    } pst_op_e;

    // Output stage: either nothing is on the bus or one registered write is.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } pst_state_e;

endpackage

// File: rtl/pst_decode.sv
module pst_decode
    import pst_pkg::*;
#(
    parameter int LANE_W = 3
) (
    input  logic [LANE_W-1:0] addr_lo,
    input  pst_op_e           op,
    input  logic              big_end,
    output logic [LANE_W-1:0] idx,
    output logic [LANE_W:0]   count,
    output logic              ascend,
    output logic              from_msb,
    output logic              wide
);
    localparam logic [LANE_W-1:0] FULL_MASK = '1;
    localparam logic [LANE_W-1:0] HALF_MASK = FULL_MASK >> 1;

    logic [LANE_W-1:0] grp_mask;
    logic              is_right;

    always_comb begin
        wide     = op[1];
        is_right = op[0];
        grp_mask = wide ? FULL_MASK : HALF_MASK;
        // Lane index: low address bits, inverted for little-endian ordering.
        idx      = (big_end ? addr_lo : ~addr_lo) & grp_mask;
        if (is_right) begin
            count = {1'b0, idx} + (LANE_W+1)'(1);
        end else begin
            count = {1'b0, grp_mask} + (LANE_W+1)'(1) - {1'b0, idx};
        end
        // Left+big-endian and right+little-endian walk toward higher lanes.
        ascend   = big_end ^ is_right;
        from_msb = ~is_right;
    end

endmodule

// File: rtl/pst_steer.sv
module pst_steer #(
    parameter int NB     = 8,
    parameter int LANE_W = 3
) (
    input  logic [LANE_W-1:0] addr_lo,
    input  logic [LANE_W:0]   count,
    input  logic              ascend,
    input  logic              from_msb,
    input  logic              wide,
    input  logic [8*NB-1:0]   wdata,
    output logic [NB-1:0]     be,
    output logic [8*NB-1:0]   data
);
    localparam logic [LANE_W-1:0] LAST_FULL = '1;
    localparam logic [LANE_W-1:0] LAST_HALF = LAST_FULL >> 1;

    logic [LANE_W-1:0] lane;
    logic [LANE_W-1:0] src;
    logic [LANE_W-1:0] k_l;
    logic [LANE_W-1:0] grp_last;

    always_comb begin
        be       = '0;
        data     = '0;
        lane     = '0;
        src      = '0;
        k_l      = '0;
        grp_last = wide ? LAST_FULL : LAST_HALF;
        for (int k = 0; k < NB; k++) begin
            if ((LANE_W+1)'(k) < count) begin
                k_l  = LANE_W'(k);
                lane = ascend ? (addr_lo + k_l) : (addr_lo - k_l);
                src  = from_msb ? (grp_last - k_l) : k_l;
                be[lane] = 1'b1;
                data[{lane, 3'b000} +: 8] = wdata[{src, 3'b000} +: 8];
            end
        end
    end

endmodule

// File: rtl/partial_store_lanes.sv
module partial_store_lanes
    import pst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic                req_big_endian,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_data,
    output logic                wr_valid,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W/8-1:0] wr_strobe
);
    localparam int NB     = DATA_W / 8;
    localparam int LANE_W = $clog2(NB);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(NB - 1);

    pst_state_e state_q, state_d;

    logic [LANE_W-1:0] idx;
    logic [LANE_W:0]   count;
    logic              ascend;
    logic              from_msb;
    logic              wide;
    logic [NB-1:0]     nxt_be;
    logic [DATA_W-1:0] nxt_data;

    pst_decode #(.LANE_W(LANE_W)) i_decode (
        .addr_lo (req_addr[LANE_W-1:0]),
        .op      (pst_op_e'(req_op)),
        .big_end (req_big_endian),
        .idx     (idx),
        .count   (count),
        .ascend  (ascend),
        .from_msb(from_msb),
        .wide    (wide)
    );

    pst_steer #(.NB(NB), .LANE_W(LANE_W)) i_steer (
        .addr_lo (req_addr[LANE_W-1:0]),
        .count   (count),
        .ascend  (ascend),
        .from_msb(from_msb),
        .wide    (wide),
        .wdata   (req_data),
        .be      (nxt_be),
        .data    (nxt_data)
    );

    // Next state: ACCEPT, STREAM and DRAIN transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = req_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: loaded on a request, strobes and data cleared otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_strobe <= '0;
        end else if (req_valid) begin
            wr_addr   <= req_addr & ALIGN_MASK;
            wr_data   <= nxt_data;
            wr_strobe <= nxt_be;
        end else begin
            wr_data   <= '0;
            wr_strobe <= '0;
        end
    end

    always_comb wr_valid = (state_q == ST_EMIT);

    function automatic logic [DATA_W-1:0] idle_bytes(input logic [NB-1:0] m);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int j = 0; j < NB; j++) begin
            r[j*8 +: 8] = {8{~m[j]}};
        end
        return r;
    endfunction

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> wr_valid);

    p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!wr_valid && wr_strobe == '0));

    p_left_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op[0]) |->
            ($countones(nxt_be) == ((req_op[1] ? NB : NB/2) - int'(idx))));

    p_right_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op[0]) |-> ($countones(nxt_be) == int'(idx) + 1));

    p_anchor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> nxt_be[req_addr[LANE_W-1:0]]);

    p_word_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op[1]) |->
            (nxt_be[NB-1:NB/2] == '0 || nxt_be[NB/2-1:0] == '0));

    p_quiet_lanes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_data & idle_bytes(wr_strobe)) == '0));

endmodule

// File: tb/test_partial_store_lanes.sv
`timescale 1ns/1ps
module test_partial_store_lanes;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic        req_big_endian = 1'b0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_data = '0;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [63:0] wr_data;
    logic [7:0]  wr_strobe;

    int n_checks = 0;
    int n_err    = 0;

    always #2.5 clk = ~clk;

    partial_store_lanes i_partial_store_lanes (
        .clk, .rst_n, .req_valid, .req_op, .req_big_endian,
        .req_addr, .req_data, .wr_valid, .wr_addr, .wr_data, .wr_strobe
    );

    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam logic [63:0] PAT  = 64'h0807_0605_0403_0201;

    // {op, big_endian, addr_lo, expected strobe, expected data}, data = PAT
    localparam logic [77:0] VEC [13] = '{
        {2'b00, 1'b1, 3'd0, 8'h0F, 64'h0000_0000_0102_0304}, // R9 R4 BE left word full
        {2'b00, 1'b1, 3'd6, 8'hC0, 64'h0304_0000_0000_0000}, // R8 upper word
        {2'b00, 1'b0, 3'd3, 8'h0F, 64'h0000_0000_0403_0201}, // R9 LE left word full
        {2'b00, 1'b0, 3'd5, 8'h30, 64'h0000_0403_0000_0000}, // R6 LE descends
        {2'b01, 1'b1, 3'd1, 8'h03, 64'h0000_0000_0000_0102}, // R5 BE right
        {2'b01, 1'b0, 3'd4, 8'hF0, 64'h0403_0201_0000_0000}, // R5 LE right full
        {2'b01, 1'b1, 3'd7, 8'hF0, 64'h0102_0304_0000_0000}, // R6 BE right down
        {2'b10, 1'b1, 3'd0, 8'hFF, 64'h0102_0304_0506_0708}, // R7 left dword full
        {2'b10, 1'b1, 3'd5, 8'hE0, 64'h0607_0800_0000_0000}, // R7 left dword part
        {2'b10, 1'b0, 3'd2, 8'h07, 64'h0000_0000_0008_0706}, // R3 LE dword index
        {2'b11, 1'b1, 3'd3, 8'h0F, 64'h0000_0000_0102_0304}, // R7 right dword
        {2'b11, 1'b0, 3'd6, 8'hC0, 64'h0201_0000_0000_0000}, // R3 LE right dword
        {2'b11, 1'b0, 3'd0, 8'hFF, 64'h0807_0605_0403_0201}  // R7 right dword full
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic be, input logic [31:0] a,
                         input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_big_endian = be; req_addr = a; req_data = d;
        @(negedge clk);
    endtask

    // Reference: lane by lane within the aligned group holding the address.
    task automatic model(input logic [1:0] op, input logic bige, input logic [2:0] a,
                         input logic [63:0] d, output logic [7:0] mbe, output logic [63:0] md);
        int n, ap, p, b;
        bit hit;
        n  = op[1] ? 8 : 4;
        ap = int'(a) % n;
        mbe = '0; md = '0;
        for (int j = 0; j < 8; j++) begin
            if ((j / n) == (int'(a) / n)) begin
                p = j % n;
                hit = 1'b0; b = 0;
                if (!op[0] && bige && p >= ap)  begin hit = 1'b1; b = n - 1 - (p - ap); end
                if (!op[0] && !bige && p <= ap) begin hit = 1'b1; b = n - 1 - (ap - p); end
                if (op[0] && bige && p <= ap)   begin hit = 1'b1; b = ap - p; end
                if (op[0] && !bige && p >= ap)  begin hit = 1'b1; b = p - ap; end
                if (hit) begin
                    mbe[j] = 1'b1;
                    md[j*8 +: 8] = d[b*8 +: 8];
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++; n_checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [7:0]  ebe;
        logic [63:0] edata;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 64'(wr_valid), 64'd0);
        chk("R1 strobe in reset", 64'(wr_strobe), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 64'(wr_valid), 64'd0);
        chk("R1 strobe after reset", 64'(wr_strobe), 64'd0);

        foreach (VEC[v]) begin
            drive(VEC[v][77:76], VEC[v][75], BASE | 32'(VEC[v][74:72]), PAT);
            chk($sformatf("R2 valid vec%0d", v), 64'(wr_valid), 64'd1);
            chk($sformatf("R4/R5/R6 strobe vec%0d", v), 64'(wr_strobe), 64'(VEC[v][71:64]));
            chk($sformatf("R11 data vec%0d", v), wr_data, VEC[v][63:0]);
            chk($sformatf("R8 addr vec%0d", v), 64'(wr_addr), 64'(BASE));
        end

        // R10: no request -> next cycle idle, strobe clear
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        chk("R10 valid idle", 64'(wr_valid), 64'd0);
        chk("R10 strobe idle", 64'(wr_strobe), 64'd0);
        @(negedge clk);
        chk("R10 stays idle", 64'(wr_valid), 64'd0);

        // Sweep every op, endianness and lane offset against the model (R3 R7 R8)
        for (int op = 0; op < 4; op++) begin
            for (int e = 0; e < 2; e++) begin
                for (int a = 0; a < 8; a++) begin
                    logic [63:0] d;
                    logic [31:0] ad;
                    d  = 64'hF1E2_D3C4_B5A6_9788 ^ {8{8'(op * 16 + e * 8 + a)}};
                    ad = 32'h0ABC_0000 + 32'(op * 256 + e * 64) + 32'(a);
                    model(2'(op), e[0], 3'(a), d, ebe, edata);
                    drive(2'(op), e[0], ad, d);
                    chk($sformatf("R3 strobe op%0d e%0d a%0d", op, e, a),
                        64'(wr_strobe), 64'(ebe));
                    chk($sformatf("R7 data op%0d e%0d a%0d", op, e, a), wr_data, edata);
                    chk($sformatf("R8 addr op%0d e%0d a%0d", op, e, a),
                        64'(wr_addr), 64'(ad & 32'hFFFF_FFF8));
                end
            end
        end

        // Back-to-back requests then drain (R2 R10)
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        chk("R10 drain after sweep", 64'(wr_valid), 64'd0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule